// File: doc/BRIEF.md
# Integer Subtract Execution Unit

This unit executes the scalar integer subtract instructions of a 64-bit load/store architecture. Each cycle it may accept one 32-bit instruction word. Alongside the word come the values read for the first source register, the second source register and the stack pointer. The unit recognises three ways of forming the second operand:

- a register shifted by an immediate amount;
- a register narrowed to a byte, halfword, word or doubleword, extended with zeros or with its sign, then shifted left;
- a 12-bit unsigned immediate, optionally moved up by 12 bit positions.

Each of these comes in a 32-bit and a 64-bit data size.

The difference is formed as the first operand plus the bitwise inverse of the second operand plus one. Register index 31 is read and written differently by form. In the shifted form it is the zero register. In the extended and immediate forms, as the base or destination, it is the stack pointer.

A word that matches no form, or uses a reserved field value, is reported as undefined and writes nothing. All results leave through one registered stage. `outValid` follows `inValid` by one clock.

Top module: `isub_exec`

## Requirements
- R1: Shifted form: a word with bits [30:24] = 1001011 and bit 21 = 0 is decoded as follows. Bits [23:22] give the shift kind: 00 is logical left, 01 is logical right and 10 is arithmetic right. Bits [15:10] give the amount, bits [20:16] give Rm, bits [9:5] give Rn and bits [4:0] give Rd. The result is Rn minus the shifted Rm.
- R2: Extended form: a word with bits [30:21] = 1001011001 decodes bits [15:13] as the extension kind. Kinds 0..3 zero-extend the low 8, 16, 32 or 64 bits of Rm. Kinds 4..7 sign-extend the same sizes. The extended value is then shifted left by bits [12:10], and the result is the base minus that value.
- R3: Immediate form: a word with bits [30:23] = 10100010 takes bits [21:10] as an unsigned immediate. When bit 22 is 1 the immediate is shifted left by 12 before it is subtracted.
- R4: Bit 31 = 0 selects 32-bit size. Only the low 32 bits of the operands count, right shifts work on 32-bit values, and result bits [63:32] are zero.
- R5: In the shifted form, Rn or Rm = 31 reads as zero. Rd = 31 discards the write, so `wrEn` and `wrSp` are both 0.
- R6: In the extended and immediate forms, Rn = 31 reads `spValue`, and Rm = 31 in the extended form reads zero. Rd = 31 gives `wrSp` = 1 with `wrEn` = 0. Any other Rd gives `wrEn` = 1 with `wrSp` = 0.
- R7: The following words give `undef` = 1, `wrEn` = `wrSp` = 0, `result` = 0 and `dstIdx` = 0: a word matching no form, shift kind 11, a 32-bit shifted word whose amount has bit 5 set, and an extended word whose left shift exceeds 4.
- R8: All outputs are registered: the values for a word accepted at one clock edge appear after that edge. `outValid` copies `inValid` with one cycle of delay and is 0 after a synchronous active-high reset. While `outValid` is 0, `wrEn`, `wrSp` and `undef` are 0.
- R9: The difference wraps modulo 2 to the data size. For example, 0 minus 1 gives all ones in the selected size.
- R10: For a defined word, `dstIdx` carries Rd.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Instruction word and operands are present |
| instr | input | 32 | Instruction word |
| srcA | input | 64 | Value read for register Rn |
| srcB | input | 64 | Value read for register Rm |
| spValue | input | 64 | Current stack pointer value |
| outValid | output | 1 | Registered outputs belong to an accepted word |
| dstIdx | output | 5 | Destination register index |
| result | output | 64 | Difference, zero-extended in 32-bit size |
| wrEn | output | 1 | Write `result` to general register `dstIdx` |
| wrSp | output | 1 | Write `result` to the stack pointer |
| undef | output | 1 | Word was not a recognised subtract |

## Verification
The bench aims at the places where the three forms treat register 31 differently. A design that mixed up the forms would read the stack pointer where zero belongs, or write the stack pointer when the write should be discarded.

It drives 32-bit arithmetic right shifts on words whose upper halves are not zero. A unit that shifted the full 64 bits would pull garbage into bit 31.

All eight extension kinds are covered, including sign extension of negative bytes and halfwords, along with the borrow wrap at zero. The reserved encodings (shift kind 11, amounts of 32 or more in 32-bit size, extend shifts above 4) must each raise `undef` and produce no write.

// File: rtl/isub_pkg.sv
`timescale 1ns/1ps
package isub_pkg;
  localparam int XLEN    = 64;
  localparam int INSN_W  = 32;
  localparam int REG_W   = 5;
  localparam int SHAMT_W = 6;
  localparam int IMM_W   = 12;
  localparam int EXT_W   = 3;
  localparam int EXTSH_W = 3;
  localparam int EXTSH_MAX = 4;
  localparam logic [REG_W-1:0] REG_SPECIAL = '1;

  typedef enum logic [1:0] {FORM_NONE, FORM_SHIFT, FORM_EXT, FORM_IMM} formE;
  typedef enum logic [1:0] {BASE_REG, BASE_ZERO, BASE_SP} baseSelE;

  typedef struct packed {
    formE               form;
    logic               wide;
    logic [1:0]         shType;
    logic [SHAMT_W-1:0] shAmt;
    logic [EXT_W-1:0]   extKind;
    logic [EXTSH_W-1:0] extLsl;
    logic               immHi;
    logic [IMM_W-1:0]   imm;
    baseSelE            baseSel;
    logic               rmZero;
    logic [REG_W-1:0]   rdIdx;
    logic               wrGpr;
    logic               wrSp;
    logic               undef;
  } ctlStrobesT;
endpackage

// File: rtl/isub_ctrl.sv
`timescale 1ns/1ps
module isub_ctrl
  import isub_pkg::*;
(
  input  logic              inValid,
  input  logic [INSN_W-1:0] instr,
  output ctlStrobesT        ctl
);
  logic isShift, isExt, isImm, reserved, known, rdSpecial, rnSpecial;

  always_comb begin
    isShift   = (instr[30:24] == 7'b1001011) && !instr[21];
    isExt     = (instr[30:21] == 10'b1001011001);
    isImm     = (instr[30:23] == 8'b10100010);
    known     = isShift || isExt || isImm;
    rdSpecial = (instr[4:0] == REG_SPECIAL);
    rnSpecial = (instr[9:5] == REG_SPECIAL);

    reserved = 1'b0;
    if (isShift && ((instr[23:22] == 2'b11) || (!instr[31] && instr[15])))
      reserved = 1'b1;
    if (isExt && (instr[12:10] > EXTSH_W'(EXTSH_MAX)))
      reserved = 1'b1;

    ctl         = '0;
    ctl.wide    = instr[31];
    ctl.shType  = instr[23:22];
    ctl.shAmt   = instr[15:10];
    ctl.extKind = instr[15:13];
    ctl.extLsl  = instr[12:10];
    ctl.immHi   = instr[22];
    ctl.imm     = instr[21:10];
    ctl.rmZero  = (instr[20:16] == REG_SPECIAL);
    ctl.rdIdx   = instr[4:0];

    if (isShift)    ctl.form = FORM_SHIFT;
    else if (isExt) ctl.form = FORM_EXT;
    else if (isImm) ctl.form = FORM_IMM;
    else            ctl.form = FORM_NONE;

    if (rnSpecial) ctl.baseSel = isShift ? BASE_ZERO : BASE_SP;
    else           ctl.baseSel = BASE_REG;

    ctl.undef = inValid && (!known || reserved);
    ctl.wrGpr = inValid && known && !reserved && !rdSpecial;
    ctl.wrSp  = inValid && known && !reserved && rdSpecial && !isShift;
  end
endmodule

// File: rtl/isub_opb.sv
`timescale 1ns/1ps
module isub_opb
  import isub_pkg::*;
#(
  parameter int W = XLEN
) (
  input  ctlStrobesT   ctl,
  input  logic [W-1:0] srcB,
  output logic [W-1:0] opB
);
  localparam int HALF = W / 2;
  localparam int HSW  = $clog2(HALF);
  localparam logic [W-1:0] LOW_MASK = {{HALF{1'b0}}, {HALF{1'b1}}};

  logic [W-1:0]    rmVal, extVal, immVal;
  logic [HALF-1:0] narrowVal, narrowShift;
  logic            sgn;

  always_comb begin
    rmVal     = ctl.rmZero ? '0 : srcB;
    narrowVal = rmVal[HALF-1:0];
    sgn       = ctl.extKind[2];

    case (ctl.shType)
      2'b00:   narrowShift = narrowVal << ctl.shAmt[HSW-1:0];
      2'b01:   narrowShift = narrowVal >> ctl.shAmt[HSW-1:0];
      default: narrowShift = $signed(narrowVal) >>> ctl.shAmt[HSW-1:0];
    endcase

    case (ctl.extKind[1:0])
      2'd0:    extVal = {{(W-8){sgn & rmVal[7]}}, rmVal[7:0]};
      2'd1:    extVal = {{(W-16){sgn & rmVal[15]}}, rmVal[15:0]};
      2'd2:    extVal = {{(W-32){sgn & rmVal[31]}}, rmVal[31:0]};
      default: extVal = rmVal;
    endcase

    immVal = {{(W-IMM_W){1'b0}}, ctl.imm};
    if (ctl.immHi) immVal = immVal << IMM_W;

    case (ctl.form)
      FORM_SHIFT: begin
        if (ctl.wide) begin
          case (ctl.shType)
            2'b00:   opB = rmVal << ctl.shAmt;
            2'b01:   opB = rmVal >> ctl.shAmt;
            default: opB = $signed(rmVal) >>> ctl.shAmt;
          endcase
        end else begin
          opB = {{HALF{1'b0}}, narrowShift};
        end
      end
      FORM_EXT: begin
        opB = extVal << ctl.extLsl;
        if (!ctl.wide) opB = opB & LOW_MASK;
      end
      FORM_IMM: opB = immVal;
      default:  opB = '0;
    endcase
  end
endmodule

// File: rtl/isub_datapath.sv
`timescale 1ns/1ps
module isub_datapath
  import isub_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  ctlStrobesT       ctl,
  input  logic [W-1:0]     srcA,
  input  logic [W-1:0]     srcB,
  input  logic [W-1:0]     spValue,
  output logic             outValid,
  output logic [REG_W-1:0] dstIdx,
  output logic [W-1:0]     result,
  output logic             wrEn,
  output logic             wrSp,
  output logic             undef
);
  localparam int HALF = W / 2;
  localparam logic [W-1:0] LOW_MASK = {{HALF{1'b0}}, {HALF{1'b1}}};

  logic [W-1:0] opA, opB, diff;
  logic         keep;

  isub_opb #(.W(W)) u_opb (
    .ctl  (ctl),
    .srcB (srcB),
    .opB  (opB)
  );

  always_comb begin
    case (ctl.baseSel)
      BASE_ZERO: opA = '0;
      BASE_SP:   opA = spValue;
      default:   opA = srcA;
    endcase
    diff = opA + ~opB + W'(1);
    if (!ctl.wide) diff = diff & LOW_MASK;
    keep = inValid && !ctl.undef;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      dstIdx   <= '0;
      result   <= '0;
      wrEn     <= 1'b0;
      wrSp     <= 1'b0;
      undef    <= 1'b0;
    end else begin
      outValid <= inValid;
      dstIdx   <= keep ? ctl.rdIdx : '0;
      result   <= keep ? diff : '0;
      wrEn     <= ctl.wrGpr;
      wrSp     <= ctl.wrSp;
      undef    <= ctl.undef;
    end
  end
endmodule

// File: rtl/isub_exec.sv
`timescale 1ns/1ps
module isub_exec
  import isub_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [INSN_W-1:0] instr,
  input  logic [W-1:0]      srcA,
  input  logic [W-1:0]      srcB,
  input  logic [W-1:0]      spValue,
  output logic              outValid,
  output logic [REG_W-1:0]  dstIdx,
  output logic [W-1:0]      result,
  output logic              wrEn,
  output logic              wrSp,
  output logic              undef
);
  ctlStrobesT ctl;

  isub_ctrl u_ctrl (
    .inValid (inValid),
    .instr   (instr),
    .ctl     (ctl)
  );

  isub_datapath #(.W(W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .ctl      (ctl),
    .srcA     (srcA),
    .srcB     (srcB),
    .spValue  (spValue),
    .outValid (outValid),
    .dstIdx   (dstIdx),
    .result   (result),
    .wrEn     (wrEn),
    .wrSp     (wrSp),
    .undef    (undef)
  );
endmodule

// File: rtl/isub_checker.sv
`timescale 1ns/1ps
module isub_checker #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rst,
  input logic         inValid,
  input logic         wideIn,
  input logic         outValid,
  input logic [4:0]   dstIdx,
  input logic [W-1:0] result,
  input logic         wrEn,
  input logic         wrSp,
  input logic         undef
);
  localparam int HALF = W / 2;

  AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst) inValid |=> outValid); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !outValid |-> (!wrEn && !wrSp && !undef)); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> !outValid); // R8
  AST_WRITE_EXCL: assert property (@(posedge clk) disable iff (rst) !(wrEn && wrSp)); // R6
  AST_SP_DEST: assert property (@(posedge clk) disable iff (rst) wrSp |-> (dstIdx == 5'd31)); // R6
  AST_ZR_DISCARD: assert property (@(posedge clk) disable iff (rst) wrEn |-> (dstIdx != 5'd31)); // R5
  AST_UNDEF_MUTE: assert property (@(posedge clk) disable iff (rst) undef |-> (!wrEn && !wrSp && result == '0)); // R7
  AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (rst) (inValid && !wideIn) |=> (result[W-1:HALF] == '0)); // R4
endmodule

bind isub_exec isub_checker #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .wideIn   (instr[31]),
  .outValid (outValid),
  .dstIdx   (dstIdx),
  .result   (result),
  .wrEn     (wrEn),
  .wrSp     (wrSp),
  .undef    (undef)
);

// File: tb/isub_exec_bench.sv
`timescale 1ns/1ps
module isub_exec_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] srcA = '0, srcB = '0, spValue = '0;
  logic        outValid, wrEn, wrSp, undef;
  logic [4:0]  dstIdx;
  logic [63:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic        pending = 0;
  logic        expValid, expWe, expWsp, expUd;
  logic [4:0]  expDst;
  logic [63:0] expRes;
  string       expTag;

  always #2.5 clk = ~clk;

  isub_exec u_isub_exec (
    .clk(clk), .rst(rst), .inValid(inValid), .instr(instr),
    .srcA(srcA), .srcB(srcB), .spValue(spValue),
    .outValid(outValid), .dstIdx(dstIdx), .result(result),
    .wrEn(wrEn), .wrSp(wrSp), .undef(undef)
  );

  function automatic logic [31:0] encShift(bit sf, logic [1:0] k, logic [4:0] rm,
                                           logic [5:0] amt, logic [4:0] rn, logic [4:0] rd);
    return {sf, 2'b10, 5'b01011, k, 1'b0, rm, amt, rn, rd};
  endfunction

  function automatic logic [31:0] encExt(bit sf, logic [4:0] rm, logic [2:0] kind,
                                         logic [2:0] lsl, logic [4:0] rn, logic [4:0] rd);
    return {sf, 2'b10, 5'b01011, 2'b00, 1'b1, rm, kind, lsl, rn, rd};
  endfunction

  function automatic logic [31:0] encImm(bit sf, bit hi, logic [11:0] imm,
                                         logic [4:0] rn, logic [4:0] rd);
    return {sf, 2'b10, 6'b100010, hi, imm, rn, rd};
  endfunction

  // Behavioural reference: plain subtraction on masked values
  task automatic model(input logic [31:0] w, input logic [63:0] a, b, sp,
                       output logic [63:0] r, output logic we, wsp, ud,
                       output logic [4:0] dst);
    logic [63:0] mask, n, m, lowMask, lp;
    int kind, amt, bits;
    logic signed [31:0] t;
    bit bad;
    mask = w[31] ? '1 : 64'h0000_0000_FFFF_FFFF;
    bad = 0; n = 0; m = 0;
    if (w[30:24] == 7'h4B && !w[21]) kind = 1;
    else if (w[30:21] == 10'b1001011001) kind = 2;
    else if (w[30:23] == 8'hA2) kind = 3;
    else kind = 0;
    case (kind)
      1: begin
        n = (w[9:5] == 31) ? 0 : a;
        m = ((w[20:16] == 31) ? 0 : b) & mask;
        amt = int'(w[15:10]);
        if (!w[31] && amt >= 32) bad = 1;
        else case (w[23:22])
          2'b00: m = (m << amt) & mask;
          2'b01: m = m >> amt;
          2'b10: if (w[31]) m = $signed(m) >>> amt;
                 else begin t = m[31:0]; t = t >>> amt; m = {32'b0, t}; end
          default: bad = 1;
        endcase
      end
      2: begin
        n = (w[9:5] == 31) ? sp : a;
        m = (w[20:16] == 31) ? 0 : b;
        bits = 8 << w[14:13];
        if (bits < 64) begin
          lowMask = (64'd1 << bits) - 1;
          lp = m & lowMask;
          if (w[15] && m[bits-1]) lp = lp | ~lowMask;
          m = lp;
        end
        if (w[12:10] > 4) bad = 1;
        m = (m << w[12:10]) & mask;
      end
      3: begin
        n = (w[9:5] == 31) ? sp : a;
        m = {52'b0, w[21:10]};
        if (w[22]) m = m << 12;
      end
      default: bad = 1;
    endcase
    if (bad) begin
      r = 0; we = 0; wsp = 0; ud = 1; dst = 0;
    end else begin
      r = (n - m) & mask; ud = 0; dst = w[4:0];
      we = (w[4:0] != 31);
      wsp = (w[4:0] == 31) && (kind != 1);
    end
  endtask

  task automatic compareNow();
    bit bad;
    if (!pending) return;
    checks++;
    bad = (outValid !== expValid);
    if (expValid)
      bad = bad || (result !== expRes) || (wrEn !== expWe) || (wrSp !== expWsp) ||
            (undef !== expUd) || (dstIdx !== expDst);
    else
      bad = bad || (wrEn !== 1'b0) || (wrSp !== 1'b0) || (undef !== 1'b0);
    if (bad) begin
      fails++;
      $display("FAIL %s: got v=%b res=%h we=%b sp=%b ud=%b dst=%0d exp v=%b res=%h we=%b sp=%b ud=%b dst=%0d",
               expTag, outValid, result, wrEn, wrSp, undef, dstIdx,
               expValid, expRes, expWe, expWsp, expUd, expDst);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] w, input logic [63:0] a, b, sp,
                      input string tag);
    @(negedge clk);
    compareNow();
    inValid = v; instr = w; srcA = a; srcB = b; spValue = sp;
    expValid = v; expTag = tag;
    if (v) model(w, a, b, sp, expRes, expWe, expWsp, expUd, expDst);
    else begin expRes = 0; expWe = 0; expWsp = 0; expUd = 0; expDst = 0; end
    pending = 1;
  endtask

  task automatic finishRun();
    if (done) return;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: got running expected finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || wrEn !== 1'b0 || wrSp !== 1'b0) begin
      fails++;
      $display("FAIL R8 reset: got v=%b we=%b sp=%b expected 0 0 0", outValid, wrEn, wrSp);
    end
    rst = 0;

    // R1 shifted-register kinds, 64-bit
    step(1, encShift(1, 2'b00, 5'd2, 6'd4, 5'd1, 5'd0), 64'd1000, 64'd3, 0, "R1 lsl");
    step(1, encShift(1, 2'b01, 5'd2, 6'd63, 5'd1, 5'd7), 64'd5, 64'h8000_0000_0000_0000, 0, "R1 lsr");
    step(1, encShift(1, 2'b10, 5'd2, 6'd8, 5'd1, 5'd9), 64'd0, 64'hF000_0000_0000_0100, 0, "R1 asr");
    step(1, encShift(1, 2'b00, 5'd3, 6'd0, 5'd4, 5'd30), 64'd77, 64'd7, 0, "R1 R10 plain");
    // R9 wrap
    step(1, encShift(1, 2'b00, 5'd3, 6'd0, 5'd4, 5'd5), 64'd0, 64'd1, 0, "R9 wrap64");
    step(1, encShift(0, 2'b00, 5'd3, 6'd0, 5'd4, 5'd5), 64'hFFFF_0000_0000_0000, 64'd1, 0, "R9 wrap32");
    // R4 narrow
    step(1, encShift(0, 2'b10, 5'd3, 6'd31, 5'd4, 5'd5), 64'h1234_0000_0000_0010, 64'hABCD_0000_8000_0000, 0, "R4 asr32");
    step(1, encShift(0, 2'b01, 5'd3, 6'd4, 5'd4, 5'd5), 64'd0, 64'hFFFF_FFFF_0000_0000, 0, "R4 lsr32");
    step(1, encExt(0, 5'd3, 3'd7, 3'd2, 5'd4, 5'd5), 64'h5555_0000_0000_0100, 64'hFFFF_FFFF_FFFF_FFF0, 0, "R4 ext32");
    // R2 all extension kinds
    for (int k = 0; k < 8; k++)
      step(1, encExt(1, 5'd6, 3'(k), 3'(k % 5), 5'd8, 5'd10),
           64'h0123_4567_89AB_CDEF, 64'h8000_8000_8000_8080, 0, "R2 ext");
    // R3 immediate
    step(1, encImm(1, 0, 12'hFFF, 5'd2, 5'd3), 64'd100000, 0, 0, "R3 imm lo");
    step(1, encImm(1, 1, 12'h001, 5'd2, 5'd3), 64'd100000, 0, 0, "R3 imm hi");
    step(1, encImm(0, 1, 12'hABC, 5'd2, 5'd3), 64'd1, 0, 0, "R3 R4 imm32");
    // R5 zero register in shifted form
    step(1, encShift(1, 2'b00, 5'd2, 6'd0, 5'd31, 5'd4), 64'd999, 64'd5, 64'd1234, "R5 rn zero");
    step(1, encShift(1, 2'b00, 5'd31, 6'd0, 5'd1, 5'd31), 64'd50, 64'd5, 64'd1234, "R5 rd discard");
    // R6 stack pointer in extended/immediate forms
    step(1, encExt(1, 5'd2, 3'd3, 3'd0, 5'd31, 5'd31), 64'd5, 64'd16, 64'h1000, "R6 ext sp");
    step(1, encImm(1, 0, 12'd32, 5'd31, 5'd31), 64'd5, 0, 64'h2000, "R6 imm sp");
    step(1, encExt(1, 5'd31, 3'd3, 3'd1, 5'd1, 5'd2), 64'd40, 64'd16, 64'h2000, "R6 rm zero");
    // R7 undefined encodings
    step(1, encShift(1, 2'b11, 5'd2, 6'd1, 5'd1, 5'd2), 64'd9, 64'd1, 0, "R7 kind11");
    step(1, encShift(0, 2'b00, 5'd2, 6'd32, 5'd1, 5'd2), 64'd9, 64'd1, 0, "R7 amt32");
    step(1, encExt(1, 5'd2, 3'd0, 3'd5, 5'd1, 5'd2), 64'd9, 64'd1, 0, "R7 lsl5");
    step(1, 32'h0000_0000, 64'd9, 64'd1, 0, "R7 zero word");
    step(1, 32'hFFFF_FFFF, 64'd9, 64'd1, 0, "R7 ones word");
    // R8 idle and back-to-back
    step(0, encImm(1, 0, 12'd1, 5'd1, 5'd2), 64'd9, 0, 0, "R8 idle");
    step(1, encImm(1, 0, 12'd1, 5'd1, 5'd2), 64'd9, 0, 0, "R8 resume");
    // R8 reset mid-stream
    step(1, encImm(1, 0, 12'd2, 5'd1, 5'd2), 64'd9, 0, 0, "R8 before reset");
    @(negedge clk);
    compareNow();
    pending = 0;
    rst = 1;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || wrEn !== 1'b0) begin
      fails++;
      $display("FAIL R8 mid reset: got v=%b we=%b expected 0 0", outValid, wrEn);
    end
    rst = 0;

    // Mixed stimulus over all forms
    for (int i = 0; i < 400; i++) begin
      logic [31:0] w;
      int f;
      f = $urandom_range(0, 3);
      case (f)
        0: w = encShift($urandom_range(0, 1), 2'($urandom), 5'($urandom), 6'($urandom),
                        5'($urandom), 5'($urandom));
        1: w = encExt($urandom_range(0, 1), 5'($urandom), 3'($urandom), 3'($urandom),
                      5'($urandom), 5'($urandom));
        2: w = encImm($urandom_range(0, 1), $urandom_range(0, 1), 12'($urandom),
                      5'($urandom), 5'($urandom));
        default: w = $urandom;
      endcase
      step($urandom_range(0, 7) != 0, w, {$urandom, $urandom}, {$urandom, $urandom},
           {$urandom, $urandom}, "R1 R2 R3 R7 mixed");
    end
    step(0, 0, 0, 0, 0, "R8 drain");
    @(negedge clk);
    compareNow();
    pending = 0;
    finishRun();
  end
endmodule